// File: doc/BRIEF.md
# Character-Packing I/O Assembly Register

This block is a 36-bit staging register that sits between a polled peripheral and the processor. Data moves through it either as whole words or as 6-bit characters. A character write packs its character into the low end and shifts earlier characters upward. A character read hands out the top character and rotates the register left, so after six reads the original word is back in place. A full flag is the handshake between the two sides. A character counter tracks how many characters remain in the current word.

Each transfer is a one-cycle strobe with a direction bit, a width bit and three qualifiers: end-of-record request, end-of-record marker and disconnect. The block returns a 2-bit result code in the same cycle as the strobe. The possible results are data-ok, end-of-record, or time-error for an overrun or underrun. A registered I/O-check pulse follows an unqualified overrun or underrun while the channel is active. Three control pulses start the channel, stop it, or post a pending end-of-record. The status flags are full, write-request, pending end-of-record, read end-of-record, disconnect, attention, active and wait.

Top module: `cpk_asm_reg`

## Requirements
- R1: Synchronous active-high reset clears every status flag, the register and io_check, and loads the character counter with 6.
- R2: A word write while not full stores word_in, sets full, clears write-request, loads the counter with 6 and returns 2'b00 (data-ok). With q_reor set it also sets read-end-of-record.
- R3: A character write while not full discards the top 6 bits, shifts the remaining 30 bits up by 6 and places char_in in bits 5:0. It returns 2'b00 and decrements the counter. The write that would take the counter to 0 sets full, clears write-request and reloads the counter to 6. The counter always stays within 1..6.
- R4: A character write with q_reor sets full and read-end-of-record, clears write-request and reloads the counter, even before six characters have been written.
- R5: A word read while full presents the register on word_out during the strobe, clears full and loads the counter with 6. It sets write-request, unless q_reor is set; in that case it clears write-request and sets read-end-of-record.
- R6: A character read while full presents bits 35:30 on char_out during the strobe and rotates the register left by 6, so bits 35:30 move to bits 5:0. It decrements the counter. The read that would take the counter to 0, or any read with q_reor, clears full and reloads the counter to 6. q_reor also clears write-request and sets read-end-of-record; otherwise write-request is set.
- R7: A write while full, or a read while empty, with an end-of-record pending returns 2'b01 (end-of-record). It clears the pending end-of-record and wait, and leaves the register unchanged. A write sets read-end-of-record; a read sets write-request.
- R8: A write while full, or a read while empty, with no end-of-record pending returns 2'b10 (time-error), sets disconnect and leaves the register unchanged. If active is set, it also sets attention. If active is set and q_disc is clear, io_check is high for exactly the next cycle.
- R9: A non-overrun write with q_weor stores its data, then clears full and the pending end-of-record, and returns 2'b01.
- R10: A read with q_weor clears the pending end-of-record and returns 2'b01. It leaves the register, full and the counter unchanged.
- R11: ctl_start sets active and wait and reloads the counter to 6. ctl_stop clears active, wait and attention. ctl_weor sets the pending end-of-record. Control effects are applied after transfer effects in the same cycle.
- R12: The result is 2'b00 whenever req_stb is low and is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_stb | input | 1 | One-cycle transfer strobe |
| req_wr | input | 1 | 1 = peripheral writes into the register, 0 = read out of it |
| req_chr | input | 1 | 1 = character transfer, 0 = word transfer |
| q_weor | input | 1 | End-of-record request qualifier |
| q_reor | input | 1 | End-of-record marker qualifier |
| q_disc | input | 1 | Disconnect qualifier, suppresses io_check |
| ctl_start | input | 1 | Start pulse: set active and wait, reload the counter |
| ctl_stop | input | 1 | Stop pulse: clear active, wait and attention |
| ctl_weor | input | 1 | Post a pending end-of-record |
| word_in | input | 36 | Word write data |
| char_in | input | 6 | Character write data |
| result | output | 2 | 00 data-ok, 01 end-of-record, 10 time-error (same cycle as strobe) |
| word_out | output | 36 | Register contents |
| char_out | output | 6 | Top character, bits 35:30 |
| char_cnt | output | 3 | Characters remaining in the current word |
| st_full | output | 1 | Full flag |
| st_wreq | output | 1 | Write-request flag |
| st_weor | output | 1 | Pending end-of-record |
| st_reor | output | 1 | Read end-of-record flag |
| st_disco | output | 1 | Disconnect flag |
| st_attn | output | 1 | Attention flag |
| st_active | output | 1 | Active flag |
| st_wait | output | 1 | Wait flag |
| io_check | output | 1 | One-cycle I/O-check pulse |

## Verification
The bench builds the block with its default parameters: 6-bit characters and six characters per word. At that size every character code is cheap to reach. It sweeps all 64 codes through a full pack of six writes followed by an unpack of six reads. Each step's word is compared against a shift-and-rotate model computed in the bench. The remaining checks cover the cases outside that loop: overrun and underrun with and without a pending end-of-record, with and without the active flag, and with the disconnect qualifier. They also cover early termination by the end-of-record marker and a counter reload from the start pulse partway through a word.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  typedef enum logic [1:0] {
    RES_OK   = 2'b00,
    RES_EOR  = 2'b01,
    RES_TERR = 2'b10
  } res_e;

  typedef struct packed {
    logic full;
    logic wreq;
    logic weor;
    logic reor;
    logic disco;
    logic attn;
    logic active;
    logic waitf;
  } flags_t;
endpackage

// File: rtl/cpk_shift_reg.sv
module cpk_shift_reg #(
  parameter int CHAR_W = 6,
  parameter int CHARS  = 6,
  localparam int WORD_W = CHAR_W * CHARS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_word,
  input  logic              shift_in,
  input  logic              rot,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CHAR_W-1:0] char_in,
  output logic [WORD_W-1:0] word_q
);
  localparam int LOW_W = WORD_W - CHAR_W;

  logic [LOW_W-1:0]  low_part;
  logic [CHAR_W-1:0] top_char;

  assign low_part = word_q[LOW_W-1:0];
  assign top_char = word_q[WORD_W-1 -: CHAR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (ld_word) begin
      word_q <= word_in;
    end else if (shift_in) begin
      word_q <= {low_part, char_in};
    end else if (rot) begin
      word_q <= {low_part, top_char};
    end
  end
endmodule

// File: rtl/cpk_char_cnt.sv
module cpk_char_cnt #(
  parameter int CHARS = 6,
  localparam int CNT_W = $clog2(CHARS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             last
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CHARS);

  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= FULL_CNT;
    end else if (reload) begin
      cnt_q <= FULL_CNT;
    end else if (dec) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cpk_ctrl.sv
module cpk_ctrl
  import cpk_pkg::*;
(
  input  logic   req_stb,
  input  logic   req_wr,
  input  logic   req_chr,
  input  logic   q_weor,
  input  logic   q_reor,
  input  logic   q_disc,
  input  logic   ctl_start,
  input  logic   ctl_stop,
  input  logic   ctl_weor,
  input  flags_t flg,
  input  logic   cnt_last,
  output res_e   res,
  output logic   ld_word,
  output logic   shift_in,
  output logic   rot,
  output logic   cnt_reload,
  output logic   cnt_dec,
  output flags_t flg_nx,
  output logic   ioc_nx
);
  logic empty_side;

  // overrun on write when full, underrun on read when empty
  assign empty_side = req_wr ? flg.full : ~flg.full;

  always_comb begin
    flg_nx     = flg;
    res        = RES_OK;
    ld_word    = 1'b0;
    shift_in   = 1'b0;
    rot        = 1'b0;
    cnt_reload = 1'b0;
    cnt_dec    = 1'b0;
    ioc_nx     = 1'b0;

    if (req_stb) begin
      if (!req_wr && q_weor) begin
        flg_nx.weor = 1'b0;
        res         = RES_EOR;
      end else if (empty_side) begin
        if (flg.weor) begin
          if (req_wr) flg_nx.reor = 1'b1;
          else        flg_nx.wreq = 1'b1;
          flg_nx.weor  = 1'b0;
          flg_nx.waitf = 1'b0;
          res          = RES_EOR;
        end else begin
          if (flg.active) begin
            flg_nx.attn = 1'b1;
            ioc_nx      = ~q_disc;
          end
          flg_nx.disco = 1'b1;
          res          = RES_TERR;
        end
      end else if (req_wr) begin
        if (!req_chr) begin
          ld_word     = 1'b1;
          cnt_reload  = 1'b1;
          flg_nx.full = 1'b1;
          flg_nx.wreq = 1'b0;
        end else begin
          shift_in = 1'b1;
          if (cnt_last || q_reor) begin
            flg_nx.full = 1'b1;
            flg_nx.wreq = 1'b0;
            cnt_reload  = 1'b1;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        if (q_reor) flg_nx.reor = 1'b1;
        if (q_weor) begin
          flg_nx.full = 1'b0;
          flg_nx.weor = 1'b0;
          res         = RES_EOR;
        end
      end else begin
        if (!req_chr) begin
          cnt_reload  = 1'b1;
          flg_nx.full = 1'b0;
        end else begin
          rot = 1'b1;
          if (cnt_last || q_reor) begin
            flg_nx.full = 1'b0;
            cnt_reload  = 1'b1;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        if (q_reor) begin
          flg_nx.full = 1'b0;
          flg_nx.wreq = 1'b0;
          flg_nx.reor = 1'b1;
          cnt_reload  = 1'b1;
        end else begin
          flg_nx.wreq = 1'b1;
        end
      end
    end

    if (ctl_stop) begin
      flg_nx.active = 1'b0;
      flg_nx.waitf  = 1'b0;
      flg_nx.attn   = 1'b0;
    end
    if (ctl_start) begin
      flg_nx.active = 1'b1;
      flg_nx.waitf  = 1'b1;
      cnt_reload    = 1'b1;
    end
    if (ctl_weor) flg_nx.weor = 1'b1;
  end
endmodule

// File: rtl/cpk_asm_reg.sv
module cpk_asm_reg
  import cpk_pkg::*;
#(
  parameter int CHAR_W = 6,
  parameter int CHARS  = 6,
  localparam int WORD_W = CHAR_W * CHARS,
  localparam int CNT_W  = $clog2(CHARS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_stb,
  input  logic              req_wr,
  input  logic              req_chr,
  input  logic              q_weor,
  input  logic              q_reor,
  input  logic              q_disc,
  input  logic              ctl_start,
  input  logic              ctl_stop,
  input  logic              ctl_weor,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CHAR_W-1:0] char_in,
  output logic [1:0]        result,
  output logic [WORD_W-1:0] word_out,
  output logic [CHAR_W-1:0] char_out,
  output logic [CNT_W-1:0]  char_cnt,
  output logic              st_full,
  output logic              st_wreq,
  output logic              st_weor,
  output logic              st_reor,
  output logic              st_disco,
  output logic              st_attn,
  output logic              st_active,
  output logic              st_wait,
  output logic              io_check
);
  flags_t flg_q, flg_nx;
  res_e   res;
  logic   ld_word, shift_in, rot, cnt_reload, cnt_dec, cnt_last, ioc_nx;

  cpk_ctrl u_ctrl (
    .req_stb    (req_stb),
    .req_wr     (req_wr),
    .req_chr    (req_chr),
    .q_weor     (q_weor),
    .q_reor     (q_reor),
    .q_disc     (q_disc),
    .ctl_start  (ctl_start),
    .ctl_stop   (ctl_stop),
    .ctl_weor   (ctl_weor),
    .flg        (flg_q),
    .cnt_last   (cnt_last),
    .res        (res),
    .ld_word    (ld_word),
    .shift_in   (shift_in),
    .rot        (rot),
    .cnt_reload (cnt_reload),
    .cnt_dec    (cnt_dec),
    .flg_nx     (flg_nx),
    .ioc_nx     (ioc_nx)
  );

  cpk_shift_reg #(.CHAR_W(CHAR_W), .CHARS(CHARS)) u_sreg (
    .clk      (clk),
    .rst      (rst),
    .ld_word  (ld_word),
    .shift_in (shift_in),
    .rot      (rot),
    .word_in  (word_in),
    .char_in  (char_in),
    .word_q   (word_out)
  );

  cpk_char_cnt #(.CHARS(CHARS)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .reload (cnt_reload),
    .dec    (cnt_dec),
    .cnt_q  (char_cnt),
    .last   (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q    <= '0;
      io_check <= 1'b0;
    end else begin
      flg_q    <= flg_nx;
      io_check <= ioc_nx;
    end
  end

  assign result    = res;
  assign char_out  = word_out[WORD_W-1 -: CHAR_W];
  assign st_full   = flg_q.full;
  assign st_wreq   = flg_q.wreq;
  assign st_weor   = flg_q.weor;
  assign st_reor   = flg_q.reor;
  assign st_disco  = flg_q.disco;
  assign st_attn   = flg_q.attn;
  assign st_active = flg_q.active;
  assign st_wait   = flg_q.waitf;
endmodule

// File: rtl/cpk_asm_reg_chk.sv
module cpk_asm_reg_chk #(
  parameter int CHAR_W = 6,
  parameter int CHARS  = 6,
  localparam int WORD_W = CHAR_W * CHARS,
  localparam int CNT_W  = $clog2(CHARS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_stb,
  input logic              req_wr,
  input logic              req_chr,
  input logic              q_weor,
  input logic              q_disc,
  input logic              ctl_start,
  input logic              ctl_stop,
  input logic              ctl_weor,
  input logic [WORD_W-1:0] word_in,
  input logic [1:0]        result,
  input logic [WORD_W-1:0] word_out,
  input logic [CNT_W-1:0]  char_cnt,
  input logic              st_full,
  input logic              st_weor,
  input logic              st_disco,
  input logic              st_active,
  input logic              io_check
);
  logic no_ctl;
  assign no_ctl = ~ctl_start & ~ctl_stop & ~ctl_weor;

  // R12
  idle_result_chk: assert property (@(posedge clk) disable iff (rst)
    !req_stb |-> result == 2'b00);

  // R12
  no_code3_chk: assert property (@(posedge clk) disable iff (rst)
    result != 2'b11);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    char_cnt >= CNT_W'(1) && char_cnt <= CNT_W'(CHARS));

  // R8
  ioc_source_chk: assert property (@(posedge clk) disable iff (rst)
    io_check |-> $past(req_stb && result == 2'b10 && !q_disc && st_active));

  // R8
  terr_disco_chk: assert property (@(posedge clk) disable iff (rst)
    (req_stb && result == 2'b10) |=> st_disco);

  // R2
  word_store_chk: assert property (@(posedge clk) disable iff (rst)
    (req_stb && req_wr && !req_chr && !st_full && !q_weor && no_ctl)
      |=> st_full && word_out == $past(word_in));

  // R10
  weor_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_stb && !req_wr && q_weor && no_ctl)
      |=> $stable(word_out) && $stable(st_full) && !st_weor);
endmodule

bind cpk_asm_reg cpk_asm_reg_chk #(.CHAR_W(CHAR_W), .CHARS(CHARS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_stb   (req_stb),
  .req_wr    (req_wr),
  .req_chr   (req_chr),
  .q_weor    (q_weor),
  .q_disc    (q_disc),
  .ctl_start (ctl_start),
  .ctl_stop  (ctl_stop),
  .ctl_weor  (ctl_weor),
  .word_in   (word_in),
  .result    (result),
  .word_out  (word_out),
  .char_cnt  (char_cnt),
  .st_full   (st_full),
  .st_weor   (st_weor),
  .st_disco  (st_disco),
  .st_active (st_active),
  .io_check  (io_check)
);

// File: tb/cpk_asm_reg_test.sv
module cpk_asm_reg_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_stb = 0, req_wr = 0, req_chr = 0;
  logic        q_weor = 0, q_reor = 0, q_disc = 0;
  logic        ctl_start = 0, ctl_stop = 0, ctl_weor = 0;
  logic [35:0] word_in = '0;
  logic [5:0]  char_in = '0;
  logic [1:0]  result;
  logic [35:0] word_out;
  logic [5:0]  char_out;
  logic [2:0]  char_cnt;
  logic st_full, st_wreq, st_weor, st_reor, st_disco, st_attn, st_active, st_wait, io_check;

  int checks = 0;
  int errors = 0;
  logic [35:0] mw;
  logic [1:0]  r_res;
  logic [5:0]  r_chr;
  logic [35:0] r_wrd;

  always #(CLK_P/2) clk = ~clk;

  cpk_asm_reg uut (
    .clk(clk), .rst(rst), .req_stb(req_stb), .req_wr(req_wr), .req_chr(req_chr),
    .q_weor(q_weor), .q_reor(q_reor), .q_disc(q_disc),
    .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_weor(ctl_weor),
    .word_in(word_in), .char_in(char_in), .result(result), .word_out(word_out),
    .char_out(char_out), .char_cnt(char_cnt), .st_full(st_full), .st_wreq(st_wreq),
    .st_weor(st_weor), .st_reor(st_reor), .st_disco(st_disco), .st_attn(st_attn),
    .st_active(st_active), .st_wait(st_wait), .io_check(io_check)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    mw = '0;
  endtask

  task automatic xfer(input bit wr, input bit chr, input bit weor, input bit reor,
                      input bit disc, input logic [35:0] w, input logic [5:0] c);
    req_stb = 1; req_wr = wr; req_chr = chr;
    q_weor = weor; q_reor = reor; q_disc = disc;
    word_in = w; char_in = c;
    #1;
    r_res = result; r_chr = char_out; r_wrd = word_out;
    @(negedge clk);
    req_stb = 0; q_weor = 0; q_reor = 0; q_disc = 0;
    #1;
  endtask

  task automatic ctl(input bit s, input bit p, input bit e);
    ctl_start = s; ctl_stop = p; ctl_weor = e;
    @(negedge clk);
    ctl_start = 0; ctl_stop = 0; ctl_weor = 0;
    #1;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 word", word_out, 0);
    chk("R1 cnt", char_cnt, 6);
    chk("R1 flags", {st_full, st_wreq, st_weor, st_reor, st_disco, st_attn, st_active, st_wait, io_check}, 0);
    // R12 idle
    chk("R12 idle result", result, 0);

    // R3 / R6 sweep over every character code
    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < 6; k++) begin
        logic [5:0] ch;
        ch = 6'((c + k * 11) % 64);
        xfer(1, 1, 0, 0, 0, '0, ch);
        mw = {mw[29:0], ch};
        chk("R3 result", r_res, 0);
        chk("R3 word", word_out, mw);
        chk("R3 cnt", char_cnt, (k < 5) ? 5 - k : 6);
      end
      chk("R3 full", {st_full, st_wreq}, 2'b10);
      for (int k = 0; k < 6; k++) begin
        xfer(0, 1, 0, 0, 0, '0, '0);
        chk("R6 char", r_chr, mw[35:30]);
        mw = {mw[29:0], mw[35:30]};
        chk("R6 word", word_out, mw);
        chk("R6 cnt", char_cnt, (k < 5) ? 5 - k : 6);
      end
      chk("R6 empty", {st_full, st_wreq}, 2'b01);
    end

    // R2 word write with marker
    xfer(1, 0, 0, 1, 0, 36'h123456789, '0);
    chk("R2 result", r_res, 0);
    chk("R2 word", word_out, 36'h123456789);
    chk("R2 flags", {st_full, st_wreq, st_reor}, 3'b101);
    // R8 overrun, inactive
    xfer(1, 0, 0, 0, 0, 36'hFFFFFFFFF, '0);
    chk("R8 result", r_res, 2);
    chk("R8 disco attn ioc", {st_disco, st_attn, io_check}, 3'b100);
    chk("R8 word held", word_out, 36'h123456789);
    // R11 start
    ctl(1, 0, 0);
    chk("R11 active wait", {st_active, st_wait}, 2'b11);
    // R8 overrun, active
    xfer(1, 1, 0, 0, 0, '0, 6'h3F);
    chk("R8 active result", r_res, 2);
    chk("R8 attn ioc", {st_attn, io_check}, 2'b11);
    @(negedge clk); #1;
    chk("R8 ioc one cycle", io_check, 0);
    // R8 overrun, active with disconnect qualifier
    xfer(1, 0, 0, 0, 1, '0, '0);
    chk("R8 disc result", r_res, 2);
    chk("R8 disc no ioc", io_check, 0);
    // R11 stop
    ctl(0, 1, 0);
    chk("R11 stop", {st_active, st_wait, st_attn}, 0);

    // R7 overrun with pending end-of-record
    do_reset();
    ctl(1, 0, 0);
    xfer(1, 0, 0, 0, 0, 36'h0A5A5A5A5, '0);
    ctl(0, 0, 1);
    chk("R11 weor post", st_weor, 1);
    xfer(1, 0, 0, 0, 0, 36'h111111111, '0);
    chk("R7 write result", r_res, 1);
    chk("R7 write flags", {st_reor, st_weor, st_wait, st_full}, 4'b1001);
    chk("R7 word held", word_out, 36'h0A5A5A5A5);
    // R10 read with end-of-record request
    ctl(0, 0, 1);
    xfer(0, 0, 1, 0, 0, '0, '0);
    chk("R10 result", r_res, 1);
    chk("R10 flags", {st_weor, st_full}, 2'b01);
    chk("R10 word", word_out, 36'h0A5A5A5A5);
    chk("R10 cnt", char_cnt, 6);
    // R5 word read
    xfer(0, 0, 0, 0, 0, '0, '0);
    chk("R5 result", r_res, 0);
    chk("R5 data", r_wrd, 36'h0A5A5A5A5);
    chk("R5 flags", {st_full, st_wreq}, 2'b01);

    // R7 underrun with pending end-of-record
    do_reset();
    ctl(0, 0, 1);
    xfer(0, 1, 0, 0, 0, '0, '0);
    chk("R7 read result", r_res, 1);
    chk("R7 read flags", {st_wreq, st_weor, st_reor}, 3'b100);
    // R8 underrun inactive
    xfer(0, 0, 0, 0, 0, '0, '0);
    chk("R8 underrun result", r_res, 2);
    chk("R8 underrun flags", {st_disco, st_attn, io_check}, 3'b100);

    // R9 write with end-of-record request
    do_reset();
    ctl(0, 0, 1);
    xfer(1, 0, 1, 0, 0, 36'h876543210, '0);
    chk("R9 result", r_res, 1);
    chk("R9 flags", {st_full, st_weor}, 2'b00);
    chk("R9 word", word_out, 36'h876543210);
    mw = 36'h876543210;
    // R4 early marker on third character
    xfer(1, 1, 0, 0, 0, '0, 6'h15);
    xfer(1, 1, 0, 0, 0, '0, 6'h2A);
    chk("R4 cnt mid", char_cnt, 4);
    xfer(1, 1, 0, 1, 0, '0, 6'h07);
    mw = {mw[17:0], 6'h15, 6'h2A, 6'h07};
    chk("R4 result", r_res, 0);
    chk("R4 word", word_out, mw);
    chk("R4 flags", {st_full, st_reor, st_wreq}, 3'b110);
    chk("R4 cnt", char_cnt, 6);
    // R5 word read with marker
    xfer(0, 0, 0, 1, 0, '0, '0);
    chk("R5 marker data", r_wrd, mw);
    chk("R5 marker flags", {st_full, st_wreq, st_reor}, 3'b001);
    // R11 start reloads counter mid-word
    xfer(1, 1, 0, 0, 0, '0, 6'h01);
    xfer(1, 1, 0, 0, 0, '0, 6'h02);
    chk("R11 cnt before", char_cnt, 4);
    ctl(1, 0, 0);
    chk("R11 cnt reload", char_cnt, 6);
    chk("R12 idle after", result, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule